// File: doc/BRIEF.md
# Segment Register Descriptor Loader

This block holds six segment registers. Each register has a visible 16-bit selector and a hidden cache that stores a 32-bit base, a 32-bit limit and a flag for a 32-bit default operand size. A load request names a register index and a selector. In protected mode the loader picks the global or the local descriptor table from one selector bit. It checks that the whole 8-byte descriptor lies inside the table limit. It then reads the two 32-bit descriptor words through a memory read port that uses a valid/ready handshake. Finally it unpacks the scattered base and limit fields, applies the page-granularity expansion and extracts the default-size flag.

In virtual-8086 mode the loader builds the cache from the selector alone and makes no memory access. The caller sees a one-cycle `done`, `gp_fault` or `illegal_idx` pulse that ends each request. Any register can be read back through a separate index port. A summary output reports whether any of the three data-stack registers has a nonzero base, so that address generation can skip the segment add when it does not need it.

The controller is a named-state machine:
- `ST_IDLE`: accepts a request. It goes to `ST_CHECK`, or to `ST_REJECT` for a bad index.
- `ST_CHECK`: goes to `ST_UPDATE` in virtual-8086 mode, to `ST_FAULT` when the descriptor crosses the table limit, and to `ST_RD_LO` otherwise.
- `ST_RD_LO`: presents the first word address. It goes to `ST_WAIT_LO` on handshake.
- `ST_WAIT_LO`: captures the first word. It goes to `ST_RD_HI` on return.
- `ST_RD_HI`: presents the second word address. It goes to `ST_WAIT_HI` on handshake.
- `ST_WAIT_HI`: captures the second word. It goes to `ST_UPDATE` on return.
- `ST_UPDATE`, `ST_FAULT`, `ST_REJECT`: each pulses its own output and returns to `ST_IDLE`.

Top module: `seg_loader`

## Requirements
- R1: After reset, `req_ready` is 1, every selector, base, limit and default flag reads 0, `addr_base_nz` is 0, and `done`, `gp_fault` and `illegal_idx` are 0.
- R2: Register indices are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. A request with index 6 or 7 pulses `illegal_idx` one cycle after acceptance. It changes no register and makes no memory read.
- R3: Selector bit 2 picks the local table (1) or the global table (0). The byte offset is the selector with bits 2:0 cleared. Word 1 is read at table base + offset, and word 2 at table base + offset + 4. Selector bits 1:0 do not affect the address.
- R4: If offset + 7 is greater than the chosen table limit, `gp_fault` pulses, no memory read is made, and the register's base, limit and flag keep their old values. The selector readback still shows the new selector.
- R5: The cached base is {word2[31:24], word2[7:0], word1[31:16]}.
- R6: The raw limit is {word2[19:16], word1[15:0]}. When word2 bit 23 is 1, the cached limit is the raw limit shifted left by 12 with bits 11:0 set to 1. Otherwise it is the raw limit zero-extended.
- R7: The cached default flag equals word2 bit 22.
- R8: With `v86_mode` set at acceptance, the base becomes selector × 16, the limit becomes 0xFFFF and the flag becomes 0. `done` pulses two cycles after acceptance and no memory request is made.
- R9: `mem_req_valid` and `mem_addr` stay steady until `mem_req_ready` is seen. The loader waits any number of cycles for `mem_rvalid`.
- R10: `req_ready` is 1 only in the idle state. A `req_valid` raised while busy has no effect.
- R11: `addr_base_nz` is 1 exactly when the ES, SS or DS cached base is nonzero.
- R12: Exactly one of `done`, `gp_fault` and `illegal_idx` pulses for one cycle per accepted request. After a `done`, the readback port shows the new values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Load request |
| req_ready | output | 1 | Loader idle, request accepted |
| req_idx | input | 3 | Target register index |
| req_selector | input | 16 | Selector to load |
| v86_mode | input | 1 | Virtual-8086 derivation |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 32 | Global table limit in bytes |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table limit in bytes |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rd_idx | input | 3 | Readback register index |
| rd_selector | output | 16 | Selector of `rd_idx` (0 if out of range) |
| rd_base | output | 32 | Cached base of `rd_idx` |
| rd_limit | output | 32 | Cached limit of `rd_idx` |
| rd_def32 | output | 1 | Cached default flag of `rd_idx` |
| addr_base_nz | output | 1 | ES, SS or DS base nonzero |
| done | output | 1 | Load completed pulse |
| gp_fault | output | 1 | Table-limit fault pulse |
| illegal_idx | output | 1 | Bad register index pulse |

## Verification
Two conditions are hard to reach from the ports.

The first is a memory port that stalls while a second request is pending. The bench memory model holds `mem_req_ready` low for a set number of cycles on every request. While the loader waits, a task raises `req_valid` for another register and then checks that this register never changes.

The second is the exact limit edge. The bench places descriptors so that one selector ends exactly on the table limit and the next one overruns it by a single entry. This is done for both tables. A read counter in the memory model confirms that faulting and virtual-8086 loads issue no memory request.

// File: rtl/segld_pkg.sv
package segld_pkg;

    localparam int SEG_COUNT = 6;
    localparam int IDX_W     = 3;
    localparam int SEL_W     = 16;
    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;

    localparam int IDX_ES = 0;
    localparam int IDX_CS = 1;
    localparam int IDX_SS = 2;
    localparam int IDX_DS = 3;
    localparam int IDX_FS = 4;
    localparam int IDX_GS = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_LO,
        ST_WAIT_LO,
        ST_RD_HI,
        ST_WAIT_HI,
        ST_UPDATE,
        ST_FAULT,
        ST_REJECT
    } seg_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              def32;
    } seg_cache_t;

endpackage

// File: rtl/segld_desc_decode.sv
module segld_desc_decode
    import segld_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int WW = WORD_W
) (
    input  logic          v86,
    input  logic [SW-1:0] selector,
    input  logic [WW-1:0] word_lo,
    input  logic [WW-1:0] word_hi,
    output seg_cache_t    fields
);
    localparam int GRAN_BIT = 23;
    localparam int SIZE_BIT = 22;
    localparam int PAGE_SH  = 12;

    logic [19:0]       raw_limit;
    logic [ADDR_W-1:0] prot_base;
    logic [ADDR_W-1:0] prot_limit;
    logic              unused_hi_bits;

    assign raw_limit      = {word_hi[19:16], word_lo[15:0]};
    assign prot_base      = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
    assign unused_hi_bits = ^{word_hi[21:20], word_hi[15:8]};

    always_comb begin
        if (word_hi[GRAN_BIT]) begin
            prot_limit = {raw_limit, {PAGE_SH{1'b1}}};
        end else begin
            prot_limit = ADDR_W'(raw_limit);
        end
    end

    always_comb begin
        if (v86) begin
            fields.base  = ADDR_W'({selector, 4'h0});
            fields.limit = ADDR_W'(32'h0000_FFFF);
            fields.def32 = 1'b0;
        end else begin
            fields.base  = prot_base;
            fields.limit = prot_limit;
            fields.def32 = word_hi[SIZE_BIT];
        end
    end

endmodule

// File: rtl/segld_cache_bank.sv
module segld_cache_bank
    import segld_pkg::*;
#(
    parameter int NSEG = SEG_COUNT,
    parameter int IW   = IDX_W,
    parameter int SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_we,
    input  logic [IW-1:0] sel_widx,
    input  logic [SW-1:0] sel_wdata,
    input  logic          cache_we,
    input  logic [IW-1:0] cache_widx,
    input  seg_cache_t    cache_wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [SW-1:0] rd_sel,
    output seg_cache_t    rd_cache,
    output logic          base_nz
);
    logic [SW-1:0] sel_r   [NSEG];
    seg_cache_t    cache_r [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_r[g] <= '0;
            end else if (sel_we && (sel_widx == IW'(g))) begin
                sel_r[g] <= sel_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cache_r[g] <= '0;
            end else if (cache_we && (cache_widx == IW'(g))) begin
                cache_r[g] <= cache_wdata;
            end
        end
    end

    always_comb begin
        rd_sel   = '0;
        rd_cache = '0;
        for (int k = 0; k < NSEG; k++) begin
            if (rd_idx == IW'(k)) begin
                rd_sel   = sel_r[k];
                rd_cache = cache_r[k];
            end
        end
    end

    assign base_nz = |{cache_r[IDX_ES].base, cache_r[IDX_SS].base, cache_r[IDX_DS].base};

endmodule

// File: rtl/segld_fsm.sv
module segld_fsm
    import segld_pkg::*;
#(
    parameter int NSEG = SEG_COUNT,
    parameter int IW   = IDX_W,
    parameter int SW   = SEL_W,
    parameter int AW   = ADDR_W,
    parameter int WW   = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [IW-1:0] req_idx,
    input  logic [SW-1:0] req_selector,
    input  logic          v86_mode,
    input  logic [AW-1:0] gdt_base,
    input  logic [AW-1:0] gdt_limit,
    input  logic [AW-1:0] ldt_base,
    input  logic [AW-1:0] ldt_limit,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [WW-1:0] mem_rdata,
    output logic          sel_we,
    output logic          cache_we,
    output logic [IW-1:0] idx_q,
    output logic [SW-1:0] sel_q,
    output logic          v86_q,
    output logic [WW-1:0] word_lo_q,
    output logic [WW-1:0] word_hi_q,
    output logic          done,
    output logic          gp_fault,
    output logic          illegal_idx
);
    localparam int LOCAL_BIT = 2;
    localparam int DESC_LAST = 7;
    localparam int HI_OFS    = 4;

    seg_state_e    state_q, state_d;
    logic [AW-1:0] tbase_q;
    logic [AW-1:0] tlim_q;
    logic          accept;
    logic          idx_ok;
    logic [SW-1:0] offset;
    logic [AW:0]   desc_end;
    logic          over_limit;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign idx_ok     = (req_idx < IW'(NSEG));
    assign offset     = {sel_q[SW-1:3], 3'b000};
    assign desc_end   = (AW+1)'(offset) + (AW+1)'(DESC_LAST);
    assign over_limit = desc_end > {1'b0, tlim_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = idx_ok ? ST_CHECK : ST_REJECT;
                end
            end
            ST_CHECK: begin
                if (v86_q) begin
                    state_d = ST_UPDATE;
                end else if (over_limit) begin
                    state_d = ST_FAULT;
                end else begin
                    state_d = ST_RD_LO;
                end
            end
            ST_RD_LO:   if (mem_req_ready) state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rvalid)    state_d = ST_RD_HI;
            ST_RD_HI:   if (mem_req_ready) state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rvalid)    state_d = ST_UPDATE;
            ST_UPDATE:  state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            ST_REJECT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            sel_q     <= '0;
            v86_q     <= 1'b0;
            tbase_q   <= '0;
            tlim_q    <= '0;
            word_lo_q <= '0;
            word_hi_q <= '0;
        end else begin
            if (accept) begin
                idx_q   <= req_idx;
                sel_q   <= req_selector;
                v86_q   <= v86_mode;
                tbase_q <= req_selector[LOCAL_BIT] ? ldt_base  : gdt_base;
                tlim_q  <= req_selector[LOCAL_BIT] ? ldt_limit : gdt_limit;
            end
            if ((state_q == ST_WAIT_LO) && mem_rvalid) begin
                word_lo_q <= mem_rdata;
            end
            if ((state_q == ST_WAIT_HI) && mem_rvalid) begin
                word_hi_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_addr      = '0;
        sel_we        = 1'b0;
        cache_we      = 1'b0;
        done          = 1'b0;
        gp_fault      = 1'b0;
        illegal_idx   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                sel_we    = req_valid && idx_ok;
            end
            ST_RD_LO: begin
                mem_req_valid = 1'b1;
                mem_addr      = tbase_q + AW'(offset);
            end
            ST_RD_HI: begin
                mem_req_valid = 1'b1;
                mem_addr      = tbase_q + AW'(offset) + AW'(HI_OFS);
            end
            ST_UPDATE: begin
                cache_we = 1'b1;
                done     = 1'b1;
            end
            ST_FAULT:  gp_fault    = 1'b1;
            ST_REJECT: illegal_idx = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import segld_pkg::*;
#(
    parameter int NSEG = SEG_COUNT,
    parameter int IW   = IDX_W,
    parameter int SW   = SEL_W,
    parameter int AW   = ADDR_W,
    parameter int WW   = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [IW-1:0] req_idx,
    input  logic [SW-1:0] req_selector,
    input  logic          v86_mode,
    input  logic [AW-1:0] gdt_base,
    input  logic [AW-1:0] gdt_limit,
    input  logic [AW-1:0] ldt_base,
    input  logic [AW-1:0] ldt_limit,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [WW-1:0] mem_rdata,
    input  logic [IW-1:0] rd_idx,
    output logic [SW-1:0] rd_selector,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_limit,
    output logic          rd_def32,
    output logic          addr_base_nz,
    output logic          done,
    output logic          gp_fault,
    output logic          illegal_idx
);
    logic          sel_we;
    logic          cache_we;
    logic [IW-1:0] idx_q;
    logic [SW-1:0] sel_q;
    logic          v86_q;
    logic [WW-1:0] word_lo_q;
    logic [WW-1:0] word_hi_q;
    seg_cache_t    new_fields;
    seg_cache_t    rd_cache;

    segld_fsm #(.NSEG(NSEG), .IW(IW), .SW(SW), .AW(AW), .WW(WW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_idx       (req_idx),
        .req_selector  (req_selector),
        .v86_mode      (v86_mode),
        .gdt_base      (gdt_base),
        .gdt_limit     (gdt_limit),
        .ldt_base      (ldt_base),
        .ldt_limit     (ldt_limit),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .sel_we        (sel_we),
        .cache_we      (cache_we),
        .idx_q         (idx_q),
        .sel_q         (sel_q),
        .v86_q         (v86_q),
        .word_lo_q     (word_lo_q),
        .word_hi_q     (word_hi_q),
        .done          (done),
        .gp_fault      (gp_fault),
        .illegal_idx   (illegal_idx)
    );

    segld_desc_decode #(.SW(SW), .WW(WW)) u_decode (
        .v86      (v86_q),
        .selector (sel_q),
        .word_lo  (word_lo_q),
        .word_hi  (word_hi_q),
        .fields   (new_fields)
    );

    segld_cache_bank #(.NSEG(NSEG), .IW(IW), .SW(SW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_we      (sel_we),
        .sel_widx    (req_idx),
        .sel_wdata   (req_selector),
        .cache_we    (cache_we),
        .cache_widx  (idx_q),
        .cache_wdata (new_fields),
        .rd_idx      (rd_idx),
        .rd_sel      (rd_selector),
        .rd_cache    (rd_cache),
        .base_nz     (addr_base_nz)
    );

    assign rd_base  = rd_cache.base;
    assign rd_limit = rd_cache.limit;
    assign rd_def32 = rd_cache.def32;

endmodule

// File: rtl/segld_checker.sv
module segld_checker #(
    parameter int NSEG = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_idx,
    input logic        v86_mode,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic        gp_fault,
    input logic        illegal_idx
);
    logic acc_v86;
    logic acc_bad;

    assign acc_v86 = req_valid && req_ready && v86_mode && (req_idx < 3'(NSEG));
    assign acc_bad = req_valid && req_ready && (req_idx >= 3'(NSEG));

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, gp_fault, illegal_idx}));

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r8_v86_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v86 |=> !mem_req_valid);

    a_r8_v86_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v86 |=> ##1 (done && !mem_req_valid));

    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bad |=> illegal_idx);

    a_r4_fault_returns: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> !mem_req_valid);

endmodule

bind seg_loader segld_checker #(.NSEG(NSEG)) u_segld_checker (.*);

// File: tb/test_seg_loader.sv
module test_seg_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_idx = '0;
    logic [15:0] req_selector = '0;
    logic        v86_mode = 1'b0;
    logic [31:0] gdt_base = 32'h0;
    logic [31:0] gdt_limit = 32'h17;
    logic [31:0] ldt_base = 32'h100;
    logic [31:0] ldt_limit = 32'hF;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_selector;
    logic [31:0] rd_base;
    logic [31:0] rd_limit;
    logic        rd_def32;
    logic        addr_base_nz;
    logic        done;
    logic        gp_fault;
    logic        illegal_idx;

    int checks = 0;
    int failures = 0;
    int mem_reads = 0;
    int stall_cycles = 0;
    int stall_left = 0;
    logic        hs_pending = 1'b0;
    logic [31:0] hs_addr = '0;
    logic [31:0] mem [128];

    always #2.5 clk = ~clk;

    seg_loader i_seg_loader (.*);

    // memory model: all decisions at the falling edge
    always @(negedge clk) begin
        if (hs_pending) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[hs_addr[8:2]];
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
        end
        if (mem_req_valid) begin
            if (stall_left > 0) begin
                mem_req_ready = 1'b0;
                stall_left--;
            end else begin
                mem_req_ready = 1'b1;
            end
        end else begin
            mem_req_ready = 1'b0;
            stall_left = stall_cycles;
        end
        hs_pending = mem_req_valid && mem_req_ready;
        hs_addr    = mem_addr;
        if (hs_pending) mem_reads++;
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdesc(input logic [31:0] base, input logic [19:0] lim,
                                          input logic g, input logic d);
        logic [31:0] w1, w2;
        w1 = {base[15:0], lim[15:0]};
        w2 = {base[31:24], g, d, 2'b00, lim[19:16], 8'h92, base[23:16]};
        return {w2, w1};
    endfunction

    function automatic logic [31:0] exp_limit(input logic [19:0] lim, input logic g);
        return g ? {lim, 12'hFFF} : {12'h000, lim};
    endfunction

    task automatic put_desc(input int word_idx, input logic [63:0] d);
        mem[word_idx]     = d[31:0];
        mem[word_idx + 1] = d[63:32];
    endtask

    // kind: 0 timeout, 1 done, 2 fault, 3 illegal
    task automatic issue(input logic [2:0] idx, input logic [15:0] sel, input logic v86,
                         output int kind);
        kind = 0;
        @(negedge clk);
        req_valid = 1'b1; req_idx = idx; req_selector = sel; v86_mode = v86;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done)        begin kind = 1; break; end
            if (gp_fault)    begin kind = 2; break; end
            if (illegal_idx) begin kind = 3; break; end
            @(negedge clk);
        end
        if (kind == 0) begin
            failures++;
            $display("FAIL watchdog: request idx %0d never completed", idx);
        end
        @(negedge clk);
    endtask

    task automatic readback(input logic [2:0] idx, output logic [15:0] s,
                            output logic [31:0] b, output logic [31:0] l, output logic f);
        rd_idx = idx;
        #1;
        s = rd_selector; b = rd_base; l = rd_limit; f = rd_def32;
    endtask

    task automatic t_reset;
        logic [15:0] s; logic [31:0] b, l; logic f;
        check32("R1 req_ready", 32'(req_ready), 32'd1);
        check32("R1 addr_base_nz", 32'(addr_base_nz), 32'd0);
        check32("R1 pulses", 32'({done, gp_fault, illegal_idx}), 32'd0);
        for (int k = 0; k < 6; k++) begin
            readback(3'(k), s, b, l, f);
            check32("R1 reg zero", {s, 15'd0, f} | b | l, 32'd0);
        end
    endtask

    task automatic t_global_load;
        int kind; logic [15:0] s; logic [31:0] b, l; logic f;
        issue(3'd1, 16'h0008, 1'b0, kind);
        check32("R12 done kind", 32'(kind), 32'd1);
        readback(3'd1, s, b, l, f);
        check32("R3 selector", 32'(s), 32'h0008);
        check32("R5 base", b, 32'h12345678);
        check32("R6 byte limit", l, exp_limit(20'h54321, 1'b0));
        check32("R7 flag set", 32'(f), 32'd1);
        check32("R11 cs ignored", 32'(addr_base_nz), 32'd0);
    endtask

    task automatic t_local_load;
        int kind, r0; logic [15:0] s; logic [31:0] b, l; logic f;
        r0 = mem_reads;
        issue(3'd3, 16'h000F, 1'b0, kind);
        check32("R12 done kind", 32'(kind), 32'd1);
        check32("R3 two reads", 32'(mem_reads - r0), 32'd2);
        readback(3'd3, s, b, l, f);
        check32("R3 selector rpl kept", 32'(s), 32'h000F);
        check32("R5 local base", b, 32'h00ABCDE0);
        check32("R6 page limit", l, exp_limit(20'h00003, 1'b1));
        check32("R7 flag clear", 32'(f), 32'd0);
        check32("R11 ds nonzero", 32'(addr_base_nz), 32'd1);
    endtask

    task automatic t_limit_edge;
        int kind, r0; logic [15:0] s; logic [31:0] b, l; logic f;
        issue(3'd4, 16'h0010, 1'b0, kind);
        check32("R4 exact edge ok", 32'(kind), 32'd1);
        readback(3'd4, s, b, l, f);
        check32("R6 4G limit", l, 32'hFFFF_FFFF);
        r0 = mem_reads;
        issue(3'd1, 16'h0018, 1'b0, kind);
        check32("R4 global overrun fault", 32'(kind), 32'd2);
        check32("R4 no read", 32'(mem_reads - r0), 32'd0);
        readback(3'd1, s, b, l, f);
        check32("R4 selector written", 32'(s), 32'h0018);
        check32("R4 base kept", b, 32'h12345678);
        check32("R4 limit kept", l, 32'h00054321);
        issue(3'd3, 16'h0014, 1'b0, kind);
        check32("R4 local overrun fault", 32'(kind), 32'd2);
        readback(3'd3, s, b, l, f);
        check32("R4 local base kept", b, 32'h00ABCDE0);
    endtask

    task automatic t_v86;
        int kind, r0; logic [15:0] s; logic [31:0] b, l; logic f;
        r0 = mem_reads;
        issue(3'd4, 16'h1234, 1'b1, kind);
        check32("R8 done", 32'(kind), 32'd1);
        check32("R8 no read", 32'(mem_reads - r0), 32'd0);
        readback(3'd4, s, b, l, f);
        check32("R8 base", b, 32'h00012340);
        check32("R8 limit", l, 32'h0000FFFF);
        check32("R8 flag", 32'(f), 32'd0);
    endtask

    task automatic t_illegal;
        int kind, r0; logic [15:0] s; logic [31:0] b, l; logic f;
        r0 = mem_reads;
        issue(3'd6, 16'h0008, 1'b0, kind);
        check32("R2 illegal pulse", 32'(kind), 32'd3);
        check32("R2 no read", 32'(mem_reads - r0), 32'd0);
        check32("R2 ready again", 32'(req_ready), 32'd1);
        readback(3'd5, s, b, l, f);
        check32("R2 gs untouched", 32'(s) | b, 32'd0);
    endtask

    task automatic t_stall_busy;
        int kind; logic [15:0] s; logic [31:0] b, l; logic f;
        stall_cycles = 4;
        @(negedge clk);
        req_valid = 1'b1; req_idx = 3'd0; req_selector = 16'h0010; v86_mode = 1'b0;
        @(negedge clk);
        req_idx = 3'd5; req_selector = 16'h0008;
        for (int i = 0; i < 3; i++) begin
            check32("R10 busy not ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        kind = 0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin kind = 1; break; end
            @(negedge clk);
        end
        check32("R9 stalled load done", 32'(kind), 32'd1);
        @(negedge clk);
        readback(3'd5, s, b, l, f);
        check32("R10 gs ignored", 32'(s) | b, 32'd0);
        readback(3'd0, s, b, l, f);
        check32("R9 es limit", l, 32'hFFFF_FFFF);
        issue(3'd2, 16'h0010, 1'b0, kind);
        issue(3'd3, 16'h0010, 1'b0, kind);
        check32("R11 all zero bases", 32'(addr_base_nz), 32'd0);
        issue(3'd2, 16'h0008, 1'b0, kind);
        check32("R11 ss nonzero", 32'(addr_base_nz), 32'd1);
        stall_cycles = 0;
    endtask

    initial begin
        for (int k = 0; k < 128; k++) mem[k] = 32'hDEAD_0000 | 32'(k);
        put_desc(2, mkdesc(32'h12345678, 20'h54321, 1'b0, 1'b1));
        put_desc(4, mkdesc(32'h00000000, 20'hFFFFF, 1'b1, 1'b1));
        put_desc(6, mkdesc(32'hCAFE0000, 20'h00001, 1'b0, 1'b0));
        put_desc(66, mkdesc(32'h00ABCDE0, 20'h00003, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_load();
        t_local_load();
        t_limit_edge();
        t_v86();
        t_illegal();
        t_stall_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule